// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Pulses

This block is the receive-side character store of a UART-style peripheral. Every stored entry is 12 bits wide: the received byte plus four status bits (framing, parity, break, overrun). When the FIFO mode input is high the buffer holds up to 16 entries in arrival order. When it is low the buffer behaves as a single holding register. The mode can be switched at run time, and any change of mode flushes the buffer.

Entries come from three sources. In normal operation they come from the external receiver (a data strobe with byte and status) or from a line-break event, which stores a break-marked entry. In loopback operation both external sources are ignored and bytes written to the transmit data register are stored instead. The read side is a pop strobe, raised when software reads the data register. The oldest entry is always presented on the head output. The block reports full, empty and can-accept levels. It also emits one-cycle pulses that tell the interrupt logic to raise or drop the receive interrupt, based on the occupancy crossing a trigger level.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the buffer is empty (empty_o=1, full_o=0, can_accept_o=1), both interrupt pulses are low and the mode register reads as single-entry mode.
- R2: With FIFO mode active the buffer stores 16 entries and returns them in arrival order; full_o rises and can_accept_o falls when the 16th entry is stored.
- R3: With FIFO mode inactive the buffer holds one entry; full_o rises after a single push.
- R4: A push while the occupancy equals the active depth is dropped; the occupancy never exceeds the depth and stored entries are unchanged.
- R5: A pop presents the next entry on head_o and frees one slot; a pop of an empty buffer changes no state.
- R6: An entry holds the byte in bits [7:0], framing error in bit 8, parity error in bit 9, break in bit 10 and overrun in bit 11; rx_stat_i[3:0] maps to bits [11:8].
- R7: Outside loopback, brk_evt_i stores the entry 12'h400 (break bit set, data zero) and takes priority over rx_valid_i in the same cycle; in loopback it is ignored.
- R8: In loopback, rx_valid_i is ignored and tx_wr_i stores {4'b0000, tx_data_i}; outside loopback, tx_wr_i stores nothing.
- R9: rx_int_set_o pulses for one cycle, one cycle after an accepted push that leaves the occupancy equal to the trigger level (1).
- R10: rx_int_clr_o pulses for one cycle, one cycle after a pop that leaves the occupancy plus one equal to the trigger level; this includes a pop of an empty buffer.
- R11: A change of fifo_en_i empties the buffer and resets the read position; a push or pop in that same cycle is ignored.
- R12: Read and write positions wrap around the active depth, so long interleaved push and pop sequences keep arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | 1: 16-entry FIFO mode, 0: single holding register |
| loopback_i | input | 1 | Loopback active |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received byte |
| rx_stat_i | input | 4 | {overrun, break, parity, framing} of the received byte |
| brk_evt_i | input | 1 | Line break detected |
| tx_wr_i | input | 1 | Transmit data register write |
| tx_data_i | input | 8 | Transmitted byte |
| pop_i | input | 1 | Data register read strobe |
| head_o | output | 12 | Oldest stored entry |
| full_o | output | 1 | Occupancy equals active depth |
| empty_o | output | 1 | Occupancy is zero |
| can_accept_o | output | 1 | Occupancy below active depth |
| rx_int_set_o | output | 1 | Raise receive interrupt pulse |
| rx_int_clr_o | output | 1 | Drop receive interrupt pulse |

## Verification
A wrong occupancy count shows on full_o, empty_o and can_accept_o in the cycle right after the push or pop that corrupted it. A wrong read or write position does not show on the flags. It shows as a wrong head_o value at the next pop or the next push into an empty buffer, so the bench compares head_o against a reference queue after every cycle. A missed flush, or a mode decoded at the wrong depth, appears within one cycle as a full or empty flag that disagrees with the reference model.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
  localparam int BYTE_W  = 8;
  localparam int STAT_W  = 4;
  localparam int ENTRY_W = BYTE_W + STAT_W;

  // Bit 11 overrun, 10 break, 9 parity, 8 framing, 7:0 byte
  typedef struct packed {
    logic             ovr;
    logic             brk;
    logic             par;
    logic             frm;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rxbuf_src_sel.sv
module rxbuf_src_sel
  import uart_rxbuf_pkg::*;
(
  input  logic              loopback_i,
  input  logic              brk_evt_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic [STAT_W-1:0] rx_stat_i,
  input  logic              tx_wr_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              push_req_o,
  output rx_entry_t         push_entry_o
);
  always_comb begin
    push_req_o   = 1'b0;
    push_entry_o = '0;
    if (loopback_i) begin
      push_req_o        = tx_wr_i;
      push_entry_o.data = tx_data_i;
    end else if (brk_evt_i) begin
      push_req_o       = 1'b1;
      push_entry_o.brk = 1'b1;
    end else if (rx_valid_i) begin
      push_req_o   = 1'b1;
      push_entry_o = {rx_stat_i, rx_data_i};
    end
  end
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               wr_en_i,
  input  logic [PTR_W-1:0]   wr_addr_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]   rd_addr_i,
  output logic [ENTRY_W-1:0] rd_data_o
);
  logic [ENTRY_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en_i && (wr_addr_i == PTR_W'(g))) begin
        mem[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl #(
  parameter int DEPTH      = 16,
  parameter int TRIG_LEVEL = 1,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en_i,
  input  logic             push_req_i,
  input  logic             pop_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             can_accept_o,
  output logic             int_set_o,
  output logic             int_clr_o
);
  logic             mode_q, mode_d;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             set_q, set_d, clr_q, clr_d;

  logic [CNT_W-1:0] depth_act;
  logic [PTR_W-1:0] mask;
  logic             flush, accept, pop_eff, pop_dec;
  logic [CNT_W-1:0] cnt_after_pop;
  logic [CNT_W:0]   lvl_plus1;

  always_comb begin
    depth_act     = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);
    mask          = mode_q ? PTR_W'(DEPTH - 1) : '0;
    flush         = (fifo_en_i != mode_q);
    accept        = push_req_i && (cnt_q < depth_act) && !flush;
    pop_eff       = pop_i && !flush;
    pop_dec       = pop_eff && (cnt_q != '0);
    cnt_after_pop = cnt_q - CNT_W'(pop_dec);
    lvl_plus1     = {1'b0, cnt_after_pop} + (CNT_W+1)'(1);

    mode_d = fifo_en_i;
    set_d  = accept && (lvl_plus1 == (CNT_W+1)'(TRIG_LEVEL));
    clr_d  = pop_eff && (lvl_plus1 == (CNT_W+1)'(TRIG_LEVEL));
    if (flush) begin
      cnt_d = '0;
      rd_d  = '0;
    end else begin
      cnt_d = cnt_after_pop + CNT_W'(accept);
      rd_d  = pop_dec ? ((rd_q + PTR_W'(1)) & mask) : rd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      rd_q   <= '0;
      cnt_q  <= '0;
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      set_q  <= set_d;
      clr_q  <= clr_d;
    end
  end

  assign wr_en_o      = accept;
  assign wr_addr_o    = (rd_q + PTR_W'(cnt_q)) & mask;
  assign rd_addr_o    = rd_q;
  assign full_o       = (cnt_q == depth_act);
  assign empty_o      = (cnt_q == '0);
  assign can_accept_o = (cnt_q < depth_act);
  assign int_set_o    = set_q;
  assign int_clr_o    = clr_q;

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= depth_act);
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));
  assert_single_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (rd_q == '0));
  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_i != mode_q) |=> (empty_o && rd_q == '0));
  assert_set_needs_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_set_o |-> $past(push_req_i));
  assert_clr_needs_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr_o |-> $past(pop_i));
  assert_pop_empty_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_req_i && fifo_en_i == mode_q) |=> (empty_o && $stable(rd_q)));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int TRIG_LEVEL = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en_i,
  input  logic               loopback_i,
  input  logic               rx_valid_i,
  input  logic [BYTE_W-1:0]  rx_data_i,
  input  logic [STAT_W-1:0]  rx_stat_i,
  input  logic               brk_evt_i,
  input  logic               tx_wr_i,
  input  logic [BYTE_W-1:0]  tx_data_i,
  input  logic               pop_i,
  output logic [ENTRY_W-1:0] head_o,
  output logic               full_o,
  output logic               empty_o,
  output logic               can_accept_o,
  output logic               rx_int_set_o,
  output logic               rx_int_clr_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic             push_req, wr_en;
  rx_entry_t        push_entry;
  logic [PTR_W-1:0] wr_addr, rd_addr;

  rxbuf_src_sel u_src (
    .loopback_i  (loopback_i),
    .brk_evt_i   (brk_evt_i),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .rx_stat_i   (rx_stat_i),
    .tx_wr_i     (tx_wr_i),
    .tx_data_i   (tx_data_i),
    .push_req_o  (push_req),
    .push_entry_o(push_entry)
  );

  rxbuf_ctrl #(.DEPTH(DEPTH), .TRIG_LEVEL(TRIG_LEVEL)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en_i   (fifo_en_i),
    .push_req_i  (push_req),
    .pop_i       (pop_i),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .rd_addr_o   (rd_addr),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .can_accept_o(can_accept_o),
    .int_set_o   (rx_int_set_o),
    .int_clr_o   (rx_int_clr_o)
  );

  rxbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(push_entry),
    .rd_addr_i(rd_addr),
    .rd_data_o(head_o)
  );

  // R8: loopback blocks external data from ever being written
  assert_loopback_blocks_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loopback_i && !tx_wr_i) |-> !wr_en);
endmodule

// File: tb/uart_rx_buffer_tb.sv
module uart_rx_buffer_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic fifo_en, loopback, rx_valid, brk_evt, tx_wr, pop;
  logic [7:0] rx_data, tx_data;
  logic [3:0] rx_stat;
  logic [11:0] head;
  logic full, empty, can_acc, int_set, int_clr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int  q[$];
  bit  mode_m = 0;
  bit  exp_set = 0, exp_clr = 0;

  always #4 clk = ~clk;

  uart_rx_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en), .loopback_i(loopback),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_stat_i(rx_stat),
    .brk_evt_i(brk_evt), .tx_wr_i(tx_wr), .tx_data_i(tx_data), .pop_i(pop),
    .head_o(head), .full_o(full), .empty_o(empty), .can_accept_o(can_acc),
    .rx_int_set_o(int_set), .rx_int_clr_o(int_clr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rx_valid = 0; brk_evt = 0; tx_wr = 0; pop = 0;
  endtask

  // Advance one clock using the current inputs and compare with the model.
  task automatic cyc(input string tag);
    int depth, cnt;
    int entry;
    bit have;
    exp_set = 0; exp_clr = 0;
    if (fifo_en != mode_m) begin
      q.delete();
      mode_m = fifo_en;
    end else begin
      depth = mode_m ? 16 : 1;
      cnt = q.size();
      have = 0; entry = 0;
      if (loopback) begin
        if (tx_wr) begin have = 1; entry = tx_data; end
      end else if (brk_evt) begin
        have = 1; entry = 12'h400;
      end else if (rx_valid) begin
        have = 1; entry = {rx_stat, rx_data};
      end
      if (pop) begin
        if (q.size() > 0) void'(q.pop_front());
        exp_clr = (q.size() + 1 == 1);
      end
      if (have && cnt < depth) begin
        exp_set = (q.size() + 1 == 1);
        q.push_back(entry);
      end
    end
    @(posedge clk); #1;
    depth = mode_m ? 16 : 1;
    chk({tag, " empty"}, empty, q.size() == 0);
    chk({tag, " full"}, full, q.size() == depth);
    chk({tag, " can_accept"}, can_acc, q.size() < depth);
    chk("R9 set pulse", int_set, exp_set);
    chk("R10 clear pulse", int_clr, exp_clr);
    if (q.size() > 0) chk({tag, " head"}, head, q[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fifo_en = 0; loopback = 0; rx_data = 0; tx_data = 0; rx_stat = 0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 can_accept", can_acc, 1);
    chk("R1 set", int_set, 0); chk("R1 clr", int_clr, 0);

    // single holding register
    rx_valid = 1; rx_data = 8'h5A; rx_stat = 4'b0001; cyc("R3");
    rx_data = 8'hC3; cyc("R4");                 // dropped
    idle(); pop = 1; cyc("R5");
    cyc("R10");                                 // pop of empty
    idle(); rx_valid = 1; rx_data = 8'h11; pop = 1; cyc("R3"); // push into empty with pop
    idle(); rx_valid = 1; rx_data = 8'h22; pop = 1; cyc("R4"); // full: push refused
    idle();

    // mode switch flushes, pushes in that cycle ignored
    fifo_en = 1; rx_valid = 1; rx_data = 8'h33; cyc("R11");
    idle(); cyc("R11");

    // fill 16 with varied status
    for (int i = 0; i < 16; i++) begin
      rx_valid = 1; rx_data = 8'(i * 29 + 3); rx_stat = 4'(i); cyc("R6");
    end
    rx_data = 8'hEE; rx_stat = 0; cyc("R4");
    idle();
    for (int i = 0; i < 17; i++) begin pop = 1; cyc("R2"); end
    idle();

    // interleaved sweep with wraparound
    for (int i = 0; i < 120; i++) begin
      rx_valid = (i % 3 != 2); rx_data = 8'(i * 37); rx_stat = 4'(i % 16);
      pop = (i % 4 == 1) || (i > 80 && i % 2 == 0);
      cyc("R12");
    end
    idle();

    // break events
    brk_evt = 1; rx_valid = 1; rx_data = 8'h77; cyc("R7");
    idle(); pop = 1;
    for (int i = 0; i < 40; i++) cyc("R5");
    idle();

    // loopback
    loopback = 1;
    rx_valid = 1; rx_data = 8'h99; cyc("R8");
    idle(); brk_evt = 1; cyc("R7");
    idle(); tx_wr = 1; tx_data = 8'hA5; cyc("R8");
    tx_data = 8'h3C; rx_valid = 1; cyc("R8");
    idle(); loopback = 0; tx_wr = 1; tx_data = 8'h44; cyc("R8");
    idle(); pop = 1; cyc("R5");

    // flush with content while switching back to single mode
    idle(); rx_valid = 1; rx_data = 8'h12; cyc("R2");
    fifo_en = 0; pop = 1; cyc("R11");
    idle(); cyc("R1");
    rx_valid = 1; rx_data = 8'hF0; rx_stat = 4'b1010; cyc("R6");
    idle(); pop = 1; cyc("R10");
    idle(); cyc("R5");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule